// File: doc/BRIEF.md
# Round-Robin Three-by-Four Crossbar Switch

This block connects three requesting masters to four target ports. A master drives a request with a target port index, a 32-bit address, a write flag and 64 bits of write data, and waits for a single response carrying 64 bits of read data. Every target port has its own arbiter, so masters that aim at different targets are forwarded in the same cycle. When several masters aim at one target, only one is forwarded. The others see their ready low and wait.

Each arbiter treats the masters as equals. It starts its search at the master that follows the one it granted last, and wraps around. Once a request is accepted, that master owns the target port until the target's response handshake completes. During that time no other request reaches the port, and the response goes only to the owner. The arbiter runs again in the cycle after the response handshake.

Top module: `rrx_crossbar`

## Requirements
- R1: While reset is held and no master requests, every target request valid, every master ready and every master response valid is 0.
- R2: A target port whose arbiter is idle forwards the address, write flag and write data of the master it selects, and raises its request valid only when at least one master targets it.
- R3: Masters that aim at different target ports are all accepted in the same cycle when those ports are ready.
- R4: From the cycle after acceptance until the response handshake completes, a port forwards no new request and its owner does not change. A master that is not selected sees ready low, and it must hold its request until it is accepted.
- R5: Among the masters requesting an idle port, the one selected is the first in the cyclic order last+1, last+2, … (modulo 3), where last is the master that port accepted most recently.
- R6: After reset every port's last-accepted master is 2, so master 0 wins the first contested selection.
- R7: Response valid and read data reach only the owning master, and the port's response ready equals the owner's response ready. Every other master sees response valid 0.
- R8: A port that accepts nothing in a cycle keeps its last-accepted master unchanged.
- R9: A request index value k (0 to 3) selects target port k. A master's ready equals the target port's ready while that master is selected.
- R10: After the response handshake the port is idle in the next cycle and arbitrates again there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req_valid | input | 3 | Request valid, one bit per master |
| m_req_ready | output | 3 | Request accepted, one bit per master |
| m_req_slave | input | 3x2 | Target port index per master |
| m_req_addr | input | 3x32 | Address per master |
| m_req_write | input | 3 | Write flag per master |
| m_req_wdata | input | 3x64 | Write data per master |
| m_rsp_valid | output | 3 | Response valid per master |
| m_rsp_ready | input | 3 | Response ready per master |
| m_rsp_rdata | output | 3x64 | Read data per master |
| s_req_valid | output | 4 | Request valid per target port |
| s_req_ready | input | 4 | Request ready per target port |
| s_req_addr | output | 4x32 | Forwarded address per port |
| s_req_write | output | 4 | Forwarded write flag per port |
| s_req_wdata | output | 4x64 | Forwarded write data per port |
| s_rsp_valid | input | 4 | Response valid per port |
| s_rsp_ready | output | 4 | Response ready per port |
| s_rsp_rdata | input | 4x64 | Read data per port |

## Verification
Two functions can fall in the same cycle: a port finishing its response handshake, and another master's request waiting for that port. The bench leaves a loser waiting with its request held up while the owner's response drains. It then checks that the loser is forwarded only in the cycle after the handshake, and that the handshake cycle carries only the response. Random ready patterns on both sides make handshakes and new contests coincide often. A cycle-level reference model compares every output on every clock.

// File: rtl/rrx_pkg.sv
package rrx_pkg;

  localparam int unsigned NUM_M_DEF  = 3;
  localparam int unsigned NUM_S_DEF  = 4;
  localparam int unsigned ADDR_W_DEF = 32;
  localparam int unsigned DATA_W_DEF = 64;
  localparam int unsigned PICK_MAX   = 32;

  typedef struct packed {
    logic       found;
    logic [7:0] idx;
  } rr_pick_t;

  // Cyclic search starting after 'last'; the nearest requester wins.
  function automatic rr_pick_t rr_pick(input logic [PICK_MAX-1:0] req,
                                       input int unsigned n,
                                       input int unsigned last);
    rr_pick_t    r;
    int unsigned cand;
    r = '0;
    for (int k = PICK_MAX; k >= 1; k--) begin
      if (k <= int'(n)) begin
        cand = (last + k) % n;
        if (req[cand]) begin
          r.found = 1'b1;
          r.idx   = cand[7:0];
        end
      end
    end
    return r;
  endfunction

endpackage

// File: rtl/rrx_port_arb.sv
module rrx_port_arb #(
  parameter int unsigned NUM_M = rrx_pkg::NUM_M_DEF,
  parameter int unsigned ID_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NUM_M-1:0] hit,
  input  logic             tgt_req_ready,
  input  logic             tgt_rsp_valid,
  input  logic             owner_rsp_ready,
  output logic [NUM_M-1:0] grant_oh,
  output logic [NUM_M-1:0] owner_oh,
  output logic             busy,
  output logic             accept,
  output logic             done,
  output logic [ID_W-1:0]  last_id
);
  import rrx_pkg::*;

  localparam logic [ID_W-1:0] LAST_RST = ID_W'(NUM_M - 1);

  logic            busy_q;
  logic [ID_W-1:0] owner_q;
  logic [ID_W-1:0] last_q;
  rr_pick_t        pick;

  always_comb begin
    pick = rr_pick(PICK_MAX'(hit), NUM_M, int'(last_q));
  end

  always_comb begin
    grant_oh = '0;
    if (!busy_q && pick.found) grant_oh = NUM_M'(1) << pick.idx;
  end

  always_comb begin
    owner_oh = '0;
    if (busy_q) owner_oh = NUM_M'(1) << owner_q;
  end

  assign accept  = (|grant_oh) && tgt_req_ready;
  assign done    = busy_q && tgt_rsp_valid && owner_rsp_ready;
  assign busy    = busy_q;
  assign last_id = last_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
      last_q  <= LAST_RST;
    end else if (accept) begin
      busy_q  <= 1'b1;
      owner_q <= pick.idx[ID_W-1:0];
      last_q  <= pick.idx[ID_W-1:0];
    end else if (done) begin
      busy_q  <= 1'b0;
    end
  end

endmodule

// File: rtl/rrx_slave_mux.sv
module rrx_slave_mux #(
  parameter int unsigned NUM_M  = rrx_pkg::NUM_M_DEF,
  parameter int unsigned ADDR_W = rrx_pkg::ADDR_W_DEF,
  parameter int unsigned DATA_W = rrx_pkg::DATA_W_DEF
) (
  input  logic [NUM_M-1:0]             grant_oh,
  input  logic [NUM_M-1:0]             owner_oh,
  input  logic [NUM_M-1:0][ADDR_W-1:0] m_addr,
  input  logic [NUM_M-1:0]             m_write,
  input  logic [NUM_M-1:0][DATA_W-1:0] m_wdata,
  input  logic [NUM_M-1:0]             m_rsp_ready,
  output logic                         t_valid,
  output logic [ADDR_W-1:0]            t_addr,
  output logic                         t_write,
  output logic [DATA_W-1:0]            t_wdata,
  output logic                         owner_rsp_ready
);

  always_comb begin
    t_valid         = |grant_oh;
    t_addr          = '0;
    t_write         = 1'b0;
    t_wdata         = '0;
    owner_rsp_ready = 1'b0;
    for (int m = 0; m < int'(NUM_M); m++) begin
      if (grant_oh[m]) begin
        t_addr  = t_addr  | m_addr[m];
        t_write = t_write | m_write[m];
        t_wdata = t_wdata | m_wdata[m];
      end
      if (owner_oh[m]) owner_rsp_ready = owner_rsp_ready | m_rsp_ready[m];
    end
  end

endmodule

// File: rtl/rrx_master_mux.sv
module rrx_master_mux #(
  parameter int unsigned NUM_S  = rrx_pkg::NUM_S_DEF,
  parameter int unsigned DATA_W = rrx_pkg::DATA_W_DEF
) (
  input  logic [NUM_S-1:0]             granted_at,
  input  logic [NUM_S-1:0]             owned_at,
  input  logic [NUM_S-1:0]             t_req_ready,
  input  logic [NUM_S-1:0]             t_rsp_valid,
  input  logic [NUM_S-1:0][DATA_W-1:0] t_rsp_rdata,
  output logic                         req_ready,
  output logic                         rsp_valid,
  output logic [DATA_W-1:0]            rsp_rdata
);

  always_comb begin
    req_ready = 1'b0;
    rsp_valid = 1'b0;
    rsp_rdata = '0;
    for (int s = 0; s < int'(NUM_S); s++) begin
      if (granted_at[s]) req_ready = req_ready | t_req_ready[s];
      if (owned_at[s]) begin
        rsp_valid = rsp_valid | t_rsp_valid[s];
        rsp_rdata = rsp_rdata | t_rsp_rdata[s];
      end
    end
  end

endmodule

// File: rtl/rrx_crossbar.sv
module rrx_crossbar #(
  parameter int unsigned NUM_M  = rrx_pkg::NUM_M_DEF,
  parameter int unsigned NUM_S  = rrx_pkg::NUM_S_DEF,
  parameter int unsigned ADDR_W = rrx_pkg::ADDR_W_DEF,
  parameter int unsigned DATA_W = rrx_pkg::DATA_W_DEF,
  parameter int unsigned SEL_W  = (NUM_S > 1) ? $clog2(NUM_S) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_M-1:0]             m_req_valid,
  output logic [NUM_M-1:0]             m_req_ready,
  input  logic [NUM_M-1:0][SEL_W-1:0]  m_req_slave,
  input  logic [NUM_M-1:0][ADDR_W-1:0] m_req_addr,
  input  logic [NUM_M-1:0]             m_req_write,
  input  logic [NUM_M-1:0][DATA_W-1:0] m_req_wdata,
  output logic [NUM_M-1:0]             m_rsp_valid,
  input  logic [NUM_M-1:0]             m_rsp_ready,
  output logic [NUM_M-1:0][DATA_W-1:0] m_rsp_rdata,
  output logic [NUM_S-1:0]             s_req_valid,
  input  logic [NUM_S-1:0]             s_req_ready,
  output logic [NUM_S-1:0][ADDR_W-1:0] s_req_addr,
  output logic [NUM_S-1:0]             s_req_write,
  output logic [NUM_S-1:0][DATA_W-1:0] s_req_wdata,
  input  logic [NUM_S-1:0]             s_rsp_valid,
  output logic [NUM_S-1:0]             s_rsp_ready,
  input  logic [NUM_S-1:0][DATA_W-1:0] s_rsp_rdata
);

  localparam int unsigned ID_W = (NUM_M > 1) ? $clog2(NUM_M) : 1;

  // Named internal events, observed by the bound checker.
  logic [NUM_S-1:0][NUM_M-1:0] arb_hit;
  logic [NUM_S-1:0][NUM_M-1:0] arb_grant;
  logic [NUM_S-1:0][NUM_M-1:0] arb_owner;
  logic [NUM_S-1:0]            arb_busy;
  logic [NUM_S-1:0]            arb_accept;
  logic [NUM_S-1:0]            arb_done;
  logic [NUM_S-1:0][ID_W-1:0]  arb_last;
  logic [NUM_S-1:0]            arb_owner_rdy;
  logic [NUM_M-1:0][NUM_S-1:0] gnt_by_m;
  logic [NUM_M-1:0][NUM_S-1:0] own_by_m;

  always_comb begin
    for (int s = 0; s < int'(NUM_S); s++) begin
      for (int m = 0; m < int'(NUM_M); m++) begin
        arb_hit[s][m]  = m_req_valid[m] && (m_req_slave[m] == SEL_W'(s));
        gnt_by_m[m][s] = arb_grant[s][m];
        own_by_m[m][s] = arb_owner[s][m];
      end
    end
  end

  for (genvar gs = 0; gs < NUM_S; gs++) begin : g_port
    rrx_port_arb #(
      .NUM_M (NUM_M),
      .ID_W  (ID_W)
    ) u_arb (
      .clk             (clk),
      .rst_n           (rst_n),
      .hit             (arb_hit[gs]),
      .tgt_req_ready   (s_req_ready[gs]),
      .tgt_rsp_valid   (s_rsp_valid[gs]),
      .owner_rsp_ready (arb_owner_rdy[gs]),
      .grant_oh        (arb_grant[gs]),
      .owner_oh        (arb_owner[gs]),
      .busy            (arb_busy[gs]),
      .accept          (arb_accept[gs]),
      .done            (arb_done[gs]),
      .last_id         (arb_last[gs])
    );

    rrx_slave_mux #(
      .NUM_M  (NUM_M),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
    ) u_smux (
      .grant_oh        (arb_grant[gs]),
      .owner_oh        (arb_owner[gs]),
      .m_addr          (m_req_addr),
      .m_write         (m_req_write),
      .m_wdata         (m_req_wdata),
      .m_rsp_ready     (m_rsp_ready),
      .t_valid         (s_req_valid[gs]),
      .t_addr          (s_req_addr[gs]),
      .t_write         (s_req_write[gs]),
      .t_wdata         (s_req_wdata[gs]),
      .owner_rsp_ready (arb_owner_rdy[gs])
    );

    assign s_rsp_ready[gs] = arb_owner_rdy[gs];
  end

  for (genvar gm = 0; gm < NUM_M; gm++) begin : g_mst
    rrx_master_mux #(
      .NUM_S  (NUM_S),
      .DATA_W (DATA_W)
    ) u_mmux (
      .granted_at  (gnt_by_m[gm]),
      .owned_at    (own_by_m[gm]),
      .t_req_ready (s_req_ready),
      .t_rsp_valid (s_rsp_valid),
      .t_rsp_rdata (s_rsp_rdata),
      .req_ready   (m_req_ready[gm]),
      .rsp_valid   (m_rsp_valid[gm]),
      .rsp_rdata   (m_rsp_rdata[gm])
    );
  end

endmodule

// File: rtl/rrx_crossbar_chk.sv
module rrx_crossbar_chk #(
  parameter int unsigned NUM_M = 3,
  parameter int unsigned NUM_S = 4,
  parameter int unsigned ID_W  = 2
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_S-1:0][NUM_M-1:0] grant,
  input logic [NUM_S-1:0][NUM_M-1:0] owner,
  input logic [NUM_S-1:0]            busy,
  input logic [NUM_S-1:0]            accept,
  input logic [NUM_S-1:0]            done,
  input logic [NUM_S-1:0][ID_W-1:0]  last,
  input logic [NUM_S-1:0]            t_req_valid,
  input logic [NUM_M-1:0]            req_valid,
  input logic [NUM_M-1:0]            req_ready,
  input logic [NUM_M-1:0]            rsp_valid
);

  logic [NUM_M-1:0] owns_any;
  always_comb begin
    owns_any = '0;
    for (int s = 0; s < int'(NUM_S); s++) owns_any = owns_any | owner[s];
  end

  for (genvar s = 0; s < NUM_S; s++) begin : g_s
    AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant[s])); // R2
    AST_NO_FWD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy[s] |-> !t_req_valid[s]); // R4
    AST_OWNER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy[s] && !done[s] |=> busy[s] && $stable(owner[s])); // R4
    AST_ACCEPT_OWNS: assert property (@(posedge clk) disable iff (!rst_n)
      accept[s] |=> busy[s] && (owner[s] == $past(grant[s]))); // R4
    AST_LAST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      !accept[s] |=> $stable(last[s])); // R8
    AST_DONE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
      done[s] |=> !busy[s]); // R10
  end

  for (genvar m = 0; m < NUM_M; m++) begin : g_m
    AST_RSP_TO_OWNER: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid[m] |-> owns_any[m]); // R7
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[m] && !req_ready[m] |=> req_valid[m]); // R4
  end

endmodule

bind rrx_crossbar rrx_crossbar_chk #(
  .NUM_M (NUM_M),
  .NUM_S (NUM_S),
  .ID_W  (ID_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .grant       (arb_grant),
  .owner       (arb_owner),
  .busy        (arb_busy),
  .accept      (arb_accept),
  .done        (arb_done),
  .last        (arb_last),
  .t_req_valid (s_req_valid),
  .req_valid   (m_req_valid),
  .req_ready   (m_req_ready),
  .rsp_valid   (m_rsp_valid)
);

// File: tb/rrx_crossbar_tb.sv
module rrx_crossbar_tb;
  localparam int NM = 3;
  localparam int NS = 4;
  localparam int AW = 32;
  localparam int DW = 64;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [NM-1:0]         m_req_valid = '0;
  wire  [NM-1:0]         m_req_ready;
  logic [NM-1:0][1:0]    m_req_slave = '0;
  logic [NM-1:0][AW-1:0] m_req_addr = '0;
  logic [NM-1:0]         m_req_write = '0;
  logic [NM-1:0][DW-1:0] m_req_wdata = '0;
  wire  [NM-1:0]         m_rsp_valid;
  logic [NM-1:0]         m_rsp_ready = '0;
  wire  [NM-1:0][DW-1:0] m_rsp_rdata;
  wire  [NS-1:0]         s_req_valid;
  logic [NS-1:0]         s_req_ready = '0;
  wire  [NS-1:0][AW-1:0] s_req_addr;
  wire  [NS-1:0]         s_req_write;
  wire  [NS-1:0][DW-1:0] s_req_wdata;
  logic [NS-1:0]         s_rsp_valid = '0;
  wire  [NS-1:0]         s_rsp_ready;
  logic [NS-1:0][DW-1:0] s_rsp_rdata = '0;

  rrx_crossbar u_dut (.*);

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  // reference model
  int mb_busy[NS], mb_own[NS], mb_last[NS];
  int acc_q[NS][$];
  // bench masters and targets
  int ms_st[NM];
  bit want[NM];
  int tgt[NM];
  int acc_cyc[NM];
  bit sl_pend[NS];
  int sl_dly[NS];
  logic [AW-1:0] sl_addr[NS];
  bit rand_mode = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic model_reset();
    for (int s = 0; s < NS; s++) begin
      mb_busy[s] = 0; mb_own[s] = 0; mb_last[s] = NM - 1;
      sl_pend[s] = 0; sl_dly[s] = 0;
    end
    for (int m = 0; m < NM; m++) begin ms_st[m] = 0; want[m] = 0; end
  endtask

  task automatic drive();
    for (int m = 0; m < NM; m++) begin
      if (ms_st[m] == 0 && (want[m] || (rand_mode && $urandom % 4 == 0))) begin
        m_req_slave[m] = want[m] ? 2'(tgt[m]) : 2'($urandom % NS);
        m_req_addr[m]  = $urandom;
        m_req_write[m] = 1'($urandom);
        m_req_wdata[m] = {$urandom, $urandom};
        want[m] = 0;
        ms_st[m] = 1;
      end
      m_req_valid[m] = (ms_st[m] == 1);
      m_rsp_ready[m] = rand_mode ? ($urandom % 3 != 0) : 1'b1;
    end
    for (int s = 0; s < NS; s++) begin
      s_req_ready[s] = rand_mode ? ($urandom % 4 != 0) : 1'b1;
      s_rsp_valid[s] = sl_pend[s] && sl_dly[s] == 0;
      s_rsp_rdata[s] = {sl_addr[s], ~sl_addr[s]} ^ 64'(s);
    end
  endtask

  task automatic check_and_advance();
    int ew[NS];
    bit e_mrdy[NM];
    bit e_mrv[NM];
    logic [63:0] e_rd[NM];
    bit e_srr[NS];
    for (int m = 0; m < NM; m++) begin e_mrdy[m] = 0; e_mrv[m] = 0; e_rd[m] = '0; end
    for (int s = 0; s < NS; s++) begin
      ew[s] = -1;
      e_srr[s] = 0;
      if (mb_busy[s] == 0) begin
        for (int k = 1; k <= NM; k++) begin
          int c;
          c = (mb_last[s] + k) % NM;
          if (ew[s] < 0 && m_req_valid[c] && int'(m_req_slave[c]) == s) ew[s] = c;
        end
        if (ew[s] >= 0) e_mrdy[ew[s]] = s_req_ready[s];
      end else begin
        e_mrv[mb_own[s]] = s_rsp_valid[s];
        e_rd[mb_own[s]]  = s_rsp_rdata[s];
        e_srr[s] = m_rsp_ready[mb_own[s]];
      end
      chk(s_req_valid[s] == (ew[s] >= 0), "R2 R4 R10", $sformatf("s_req_valid[%0d]", s),
          64'(s_req_valid[s]), 64'(ew[s] >= 0));
      if (ew[s] >= 0) begin
        chk(s_req_addr[s] == m_req_addr[ew[s]], "R2", $sformatf("s_req_addr[%0d]", s),
            64'(s_req_addr[s]), 64'(m_req_addr[ew[s]]));
        chk(s_req_write[s] == m_req_write[ew[s]], "R2", $sformatf("s_req_write[%0d]", s),
            64'(s_req_write[s]), 64'(m_req_write[ew[s]]));
        chk(s_req_wdata[s] == m_req_wdata[ew[s]], "R2", $sformatf("s_req_wdata[%0d]", s),
            s_req_wdata[s], m_req_wdata[ew[s]]);
      end
      chk(s_rsp_ready[s] == e_srr[s], "R7", $sformatf("s_rsp_ready[%0d]", s),
          64'(s_rsp_ready[s]), 64'(e_srr[s]));
    end
    for (int m = 0; m < NM; m++) begin
      chk(m_req_ready[m] == e_mrdy[m], "R4 R9", $sformatf("m_req_ready[%0d]", m),
          64'(m_req_ready[m]), 64'(e_mrdy[m]));
      chk(m_rsp_valid[m] == e_mrv[m], "R7", $sformatf("m_rsp_valid[%0d]", m),
          64'(m_rsp_valid[m]), 64'(e_mrv[m]));
      if (e_mrv[m])
        chk(m_rsp_rdata[m] == e_rd[m], "R7", $sformatf("m_rsp_rdata[%0d]", m),
            m_rsp_rdata[m], e_rd[m]);
    end
    if (!rst_n) return;
    // model state for the next cycle
    for (int s = 0; s < NS; s++) begin
      if (ew[s] >= 0 && s_req_ready[s]) begin
        mb_busy[s] = 1; mb_own[s] = ew[s]; mb_last[s] = ew[s];
        acc_q[s].push_back(ew[s]);
      end else if (mb_busy[s] == 1 && s_rsp_valid[s] && m_rsp_ready[mb_own[s]]) begin
        mb_busy[s] = 0;
      end
    end
    // bench agents follow the observed handshakes
    for (int m = 0; m < NM; m++) begin
      if (m_req_valid[m] && m_req_ready[m]) begin ms_st[m] = 2; acc_cyc[m] = cyc; end
      else if (ms_st[m] == 2 && m_rsp_valid[m] && m_rsp_ready[m]) ms_st[m] = 0;
    end
    for (int s = 0; s < NS; s++) begin
      if (s_req_valid[s] && s_req_ready[s]) begin
        sl_pend[s] = 1; sl_addr[s] = s_req_addr[s];
        sl_dly[s] = rand_mode ? int'($urandom % 4) : 1;
      end else if (sl_pend[s]) begin
        if (s_rsp_valid[s] && s_rsp_ready[s]) sl_pend[s] = 0;
        else if (sl_dly[s] > 0) sl_dly[s]--;
      end
    end
  endtask

  task automatic step();
    drive();
    #1;
    check_and_advance();
    @(posedge clk);
    cyc++;
    @(negedge clk);
  endtask

  function automatic bit all_idle();
    for (int m = 0; m < NM; m++) if (ms_st[m] != 0 || want[m]) return 0;
    for (int s = 0; s < NS; s++) if (sl_pend[s]) return 0;
    return 1;
  endfunction

  task automatic wait_idle(input int limit);
    int n = 0;
    do begin step(); n++; end while (!all_idle() && n < limit);
    if (!all_idle()) chk(0, "R4", "drain timeout", 64'(n), 64'(limit));
  endtask

  task automatic expect_order(input int s, input int a, input int b, input int c, input string tag);
    int exp_n = (c < 0) ? 2 : 3;
    chk(acc_q[s].size() == exp_n, tag, "accept count", 64'(acc_q[s].size()), 64'(exp_n));
    if (acc_q[s].size() == exp_n) begin
      chk(acc_q[s][0] == a, tag, "first winner", 64'(acc_q[s][0]), 64'(a));
      chk(acc_q[s][1] == b, tag, "second winner", 64'(acc_q[s][1]), 64'(b));
      if (c >= 0) chk(acc_q[s][2] == c, tag, "third winner", 64'(acc_q[s][2]), 64'(c));
    end
    acc_q[s].delete();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(0, "R4", "watchdog expired", 64'(cyc), 64'(0));
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    model_reset();
    for (int s = 0; s < NS; s++) sl_addr[s] = '0;
    @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      step();
      chk(s_req_valid == '0 && m_req_ready == '0 && m_rsp_valid == '0, "R1", "reset outputs",
          64'({s_req_valid, m_req_ready, m_rsp_valid}), 64'(0));
    end
    rst_n = 1'b1;

    // R6 R5: three-way contest on port 1 right after reset
    for (int m = 0; m < NM; m++) begin want[m] = 1; tgt[m] = 1; end
    wait_idle(100);
    expect_order(1, 0, 1, 2, "R6 R5");

    // R8: idle cycles leave the pointer at 2; masters 0 and 2 contest
    repeat (6) step();
    want[0] = 1; tgt[0] = 1; want[2] = 1; tgt[2] = 1;
    wait_idle(100);
    expect_order(1, 0, 2, -1, "R8 R5");

    // R5: single grant of master 1 on port 3, then 0 and 2 contest: 2 wins
    want[1] = 1; tgt[1] = 3;
    wait_idle(100);
    acc_q[3].delete();
    repeat (3) step();
    want[0] = 1; tgt[0] = 3; want[2] = 1; tgt[2] = 3;
    wait_idle(100);
    expect_order(3, 2, 0, -1, "R5 R8");

    // R3 R9: distinct targets accepted in one cycle
    want[0] = 1; tgt[0] = 0; want[1] = 1; tgt[1] = 2; want[2] = 1; tgt[2] = 3;
    wait_idle(100);
    chk(acc_cyc[0] == acc_cyc[1] && acc_cyc[1] == acc_cyc[2], "R3", "concurrent accept",
        64'({acc_cyc[0][15:0], acc_cyc[1][15:0], acc_cyc[2][15:0]}),
        64'({acc_cyc[0][15:0], acc_cyc[0][15:0], acc_cyc[0][15:0]}));
    chk(acc_q[0].size() == 1 && acc_q[2].size() == 1 && acc_q[3].size() == 1, "R9",
        "one accept per selected port", 64'(acc_q[0].size() + acc_q[2].size() + acc_q[3].size()), 64'(3));
    for (int s = 0; s < NS; s++) acc_q[s].delete();

    // R10 R4 R7: random ready patterns and contests
    rand_mode = 1;
    repeat (4000) step();
    rand_mode = 0;
    wait_idle(200);
    for (int s = 0; s < NS; s++) acc_q[s].delete();

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule